// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block hides unreliable reads from a slow register. A request names a target address. The block then takes up to 100 samples of the 32-bit source and returns the value seen most often. Each accepted sample goes into a table of distinct values, each with its own occurrence count. The block also keeps a running leader, which is the entry with the highest count so far. A new entry takes the lead only when its count becomes strictly greater than the leader's.

Collection ends in one of two ways. It ends once 100 samples have been taken. It ends earlier if the leader's count goes above half of that total, because no other value can then overtake it. The outside source sees `busy` high and `rdAddr` stable for as long as samples are wanted. It returns each read on `sampleData` together with `sampleValid`. The winning value appears on `result`, and `done` pulses for one cycle.

Top module: `majority_read_filter`

## Requirements
- R1: While `busy` is low, a cycle with `start` high latches `addr` onto `rdAddr` and raises `busy` at the next clock edge.
- R2: Only cycles with both `busy` and `sampleValid` high count as samples. If no value ever holds more than 50 of them, collection stops on the 100th sample.
- R3: `result` is the value that occurs most often among the accepted samples.
- R4: When two values share the highest count, the one that reached that count first in sample order wins. It wins even if the other value appeared first in the stream.
- R5: Collection stops on the sample that brings any value's count to 51. `busy` then falls and later samples are not taken.
- R6: `done` is high for exactly one cycle. That cycle directly follows the clock edge that accepted the final sample, and `busy` is already low in it. `result` holds its value until the next completion.
- R7: A `start` while `busy` is high is ignored: `rdAddr` keeps its value and the request continues with its sample count unchanged.
- R8: The table is empty at the start of every request. Values and counts from an earlier request have no effect on the next result.
- R9: `sampleValid` while `busy` is low is ignored: `busy` and `done` stay low.
- R10: After reset, `busy`, `done`, `result` and `rdAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| addr | input | ADDR_W (8) | Address of the register to sample |
| sampleData | input | DATA_W (32) | One read of the source register |
| sampleValid | input | 1 | `sampleData` holds a new read |
| busy | output | 1 | Collection in progress; the source should supply reads |
| rdAddr | output | ADDR_W (8) | Address latched for the current request |
| result | output | DATA_W (32) | Most frequent value of the last request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs several kinds of stream through the block:
- A constant stream shows that the early stop happens at exactly 51 samples.
- A stream where every value differs runs all 100 samples and separates "first entry wins" from any other tie rule.
- Two 50/50 splits in different orders test the tie rule. In one of them the value that appears first loses, because the other reaches 50 first.
- Random streams over a three-value alphabet, and streams where a dominant value is mixed with noise, are compared against a model that counts prefixes.
- A request that begins with the previous request's winner would stop after a couple of samples if old counts survived.
- Valid gaps, a `start` during collection and `sampleValid` while idle test whether sample accounting stays exact.

// File: rtl/mvf_pkg.sv
package mvf_pkg;

  // Strobes from the sequencing control to the table datapath.
  typedef struct packed {
    logic clr;   // empty the table, start a new request
    logic take;  // fold sampleData into the table this cycle
    logic fin;   // this sample is the last one: capture the winner
  } mvfStrobe_t;

endpackage

// File: rtl/mvf_table.sv
module mvf_table
  import mvf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_SAMPLES = 100,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mvfStrobe_t        strb,
  input  logic [DATA_W-1:0] sampleData,
  output logic              majHit,
  output logic [DATA_W-1:0] result
);

  localparam int USED_W = $clog2(NUM_SAMPLES + 1);
  localparam int HALF   = NUM_SAMPLES / 2;

  logic [DATA_W-1:0] valTab [NUM_SAMPLES];
  logic [CNT_W-1:0]  cntTab [NUM_SAMPLES];
  logic [NUM_SAMPLES-1:0] matchVec;

  logic [USED_W-1:0] used;
  logic [CNT_W-1:0]  maxCnt;
  logic [DATA_W-1:0] maxVal;

  logic              hit;
  logic [USED_W-1:0] hitIdx;
  logic [CNT_W-1:0]  hitCnt;
  logic [USED_W-1:0] slot;
  logic [CNT_W-1:0]  newCnt;
  logic              newLead;

  // One comparator and one storage slot per possible distinct value.
  for (genvar i = 0; i < NUM_SAMPLES; i++) begin : gEntry
    assign matchVec[i] = (USED_W'(i) < used) && (valTab[i] == sampleData);

    always_ff @(posedge clk) begin
      if (strb.take && (slot == USED_W'(i))) begin
        valTab[i] <= sampleData;
        cntTab[i] <= newCnt;
      end
    end
  end

  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    hitCnt = '0;
    for (int i = 0; i < NUM_SAMPLES; i++) begin
      if (matchVec[i] && !hit) begin
        hit    = 1'b1;
        hitIdx = USED_W'(i);
        hitCnt = cntTab[i];
      end
    end
  end

  assign slot    = hit ? hitIdx : used;
  assign newCnt  = hit ? hitCnt + CNT_W'(1) : CNT_W'(1);
  assign newLead = newCnt > maxCnt;
  assign majHit  = newCnt > CNT_W'(HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      used   <= '0;
      maxCnt <= '0;
      maxVal <= '0;
      result <= '0;
    end else if (strb.clr) begin
      used   <= '0;
      maxCnt <= '0;
      maxVal <= '0;
    end else if (strb.take) begin
      if (!hit) used <= used + USED_W'(1);
      if (newLead) begin
        maxCnt <= newCnt;
        maxVal <= sampleData;
      end
      if (strb.fin) result <= newLead ? sampleData : maxVal;
    end
  end

endmodule

// File: rtl/mvf_ctrl.sv
module mvf_ctrl
  import mvf_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_SAMPLES = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sampleValid,
  input  logic              majHit,
  output mvfStrobe_t        strb,
  output logic              busy,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              done
);

  localparam int TAKEN_W = $clog2(NUM_SAMPLES + 1);
  localparam logic [TAKEN_W-1:0] LAST = TAKEN_W'(NUM_SAMPLES - 1);

  logic [TAKEN_W-1:0] takenCnt;

  always_comb begin
    strb.clr  = start && !busy;
    strb.take = busy && sampleValid;
    strb.fin  = strb.take && ((takenCnt == LAST) || majHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      takenCnt <= '0;
      rdAddr   <= '0;
      done     <= 1'b0;
    end else begin
      done <= strb.fin;
      if (strb.clr) begin
        busy     <= 1'b1;
        takenCnt <= '0;
        rdAddr   <= addr;
      end else if (strb.take) begin
        takenCnt <= takenCnt + TAKEN_W'(1);
        if (strb.fin) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/majority_read_filter.sv
module majority_read_filter
  import mvf_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int NUM_SAMPLES = 100,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleValid,
  output logic              busy,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  mvfStrobe_t strb;
  logic       majHit;

  mvf_ctrl #(
    .ADDR_W     (ADDR_W),
    .NUM_SAMPLES(NUM_SAMPLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .addr       (addr),
    .sampleValid(sampleValid),
    .majHit     (majHit),
    .strb       (strb),
    .busy       (busy),
    .rdAddr     (rdAddr),
    .done       (done)
  );

  mvf_table #(
    .DATA_W     (DATA_W),
    .NUM_SAMPLES(NUM_SAMPLES),
    .CNT_W      (CNT_W)
  ) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .sampleData(sampleData),
    .majHit    (majHit),
    .result    (result)
  );

endmodule

// File: rtl/majority_read_filter_chk.sv
module majority_read_filter_chk #(
  parameter int ADDR_W      = 8,
  parameter int NUM_SAMPLES = 100
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              sampleValid,
  input logic              busy,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              done
);

  int acceptedCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acceptedCnt <= 0;
    else if (start && !busy) acceptedCnt <= 0;
    else if (busy && sampleValid) acceptedCnt <= acceptedCnt + 1;
  end

  // R1: an idle start opens a request
  a_r1_launch: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  // R2: never more samples than the request size
  a_r2_sample_limit: assert property (@(posedge clk) disable iff (!rstN)
    acceptedCnt <= NUM_SAMPLES);

  // R6: completion is a single-cycle pulse after a busy cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  // R7: start during a request leaves the address alone
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |=> $stable(rdAddr));

  // R9: valid strobes while idle start nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !start |=> !busy && !done);

endmodule

bind majority_read_filter majority_read_filter_chk #(
  .ADDR_W     (ADDR_W),
  .NUM_SAMPLES(NUM_SAMPLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .sampleValid(sampleValid),
  .busy       (busy),
  .rdAddr     (rdAddr),
  .done       (done)
);

// File: tb/majority_read_filter_tb.sv
`timescale 1ns/1ps
module majority_read_filter_tb;

  localparam int N = 100;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        busy;
  logic [7:0]  rdAddr;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int failures = 0;
  logic [31:0] smp [N];

  always #2.5 clk = ~clk;

  majority_read_filter u_dut (
    .clk(clk), .rstN(rstN), .start(start), .addr(addr),
    .sampleData(sampleData), .sampleValid(sampleValid),
    .busy(busy), .rdAddr(rdAddr), .result(result), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Number of samples the request consumes: stops when a count passes half.
  function automatic int expTaken();
    for (int k = 0; k < N; k++) begin
      int c = 0;
      for (int j = 0; j <= k; j++) if (smp[j] == smp[k]) c++;
      if (c > N / 2) return k + 1;
    end
    return N;
  endfunction

  // Value that first reaches the highest prefix count.
  function automatic logic [31:0] expMode(input int n);
    int best = 0;
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) begin
      int c = 0;
      for (int j = 0; j <= k; j++) if (smp[j] == smp[k]) c++;
      if (c > best) begin
        best = c;
        v = smp[k];
      end
    end
    return v;
  endfunction

  task automatic runReq(input string tag, input logic [7:0] a, input int gapPct, input bit midStart);
    int taken = 0;
    int guard = 0;
    int n = expTaken();
    logic [31:0] m = expMode(n);
    @(negedge clk);
    start = 1'b1; addr = a;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R1 busy"}, 32'(busy), 32'd1);
    check({tag, " R1 rdAddr"}, 32'(rdAddr), 32'(a));
    while (!done && guard < 5000) begin
      guard++;
      if (busy && taken < N && int'($urandom_range(99)) >= gapPct) begin
        sampleValid = 1'b1;
        sampleData = smp[taken];
        taken++;
      end else begin
        sampleValid = 1'b0;
        sampleData = $urandom;
      end
      if (midStart && taken == 20) begin
        start = 1'b1; addr = ~a;
      end
      @(negedge clk);
      start = 1'b0;
      sampleValid = 1'b0;
      if (midStart && taken == 20 && busy)
        check({tag, " R7 rdAddr held"}, 32'(rdAddr), 32'(a));
    end
    check({tag, " R6 done seen"}, 32'(done), 32'd1);
    check({tag, " R6 busy low with done"}, 32'(busy), 32'd0);
    check({tag, " R2/R5 samples taken"}, 32'(taken), 32'(n));
    check({tag, " R3/R4 result"}, result, m);
    // R9: a valid strobe after completion must not be taken
    sampleValid = 1'b1; sampleData = 32'hDEAD_BEEF;
    @(negedge clk);
    sampleValid = 1'b0;
    check({tag, " R6 done single"}, 32'(done), 32'd0);
    check({tag, " R6 result held"}, result, m);
    check({tag, " R9 idle"}, 32'(busy), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R10 busy", 32'(busy), 0);
    check("R10 done", 32'(done), 0);
    check("R10 result", result, 0);
    check("R10 rdAddr", 32'(rdAddr), 0);
    rstN = 1'b1;

    // R9: valid while idle
    repeat (4) begin
      @(negedge clk); sampleValid = 1'b1; sampleData = 32'h55;
    end
    @(negedge clk); sampleValid = 1'b0;
    check("R9 busy idle", 32'(busy), 0);
    check("R9 done idle", 32'(done), 0);

    // R5: constant stream stops at 51
    for (int i = 0; i < N; i++) smp[i] = 32'hA5A5_0001;
    runReq("const", 8'h11, 0, 1'b0);

    // R8: previous winner appears only twice now
    for (int i = 0; i < N; i++) smp[i] = 32'h1000 + 32'(i);
    smp[0] = 32'hA5A5_0001; smp[1] = 32'hA5A5_0001;
    runReq("clear", 8'h12, 20, 1'b0);

    // R2/R4: all distinct, first entry wins
    for (int i = 0; i < N; i++) smp[i] = 32'(i) * 7 + 3;
    runReq("distinct", 8'h13, 30, 1'b1);

    // R4: alternating tie
    for (int i = 0; i < N; i++) smp[i] = (i % 2 == 0) ? 32'hAAAA : 32'hBBBB;
    runReq("alt tie", 8'h14, 0, 1'b0);

    // R4: first-appearing value reaches 50 last
    for (int i = 0; i < N; i++) smp[i] = (i < 2 || i >= 52) ? 32'hAAAA : 32'hBBBB;
    runReq("late tie", 8'h15, 10, 1'b0);

    // R5: late early stop after distinct prefix
    for (int i = 0; i < N; i++) smp[i] = (i < 10) ? 32'h2000 + 32'(i) : 32'hC0DE;
    runReq("late stop", 8'h16, 25, 1'b0);

    // R3: random three-value alphabet
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < N; i++) smp[i] = 32'h300 + 32'($urandom_range(2));
      runReq("rand3", 8'(r), 15, r == 2);
    end

    // R3/R5: dominant value with noisy reads
    for (int r = 0; r < 6; r++) begin
      logic [31:0] dom = $urandom;
      for (int i = 0; i < N; i++)
        smp[i] = ($urandom_range(99) < 70) ? dom : (dom ^ (32'd1 << $urandom_range(31)));
      runReq("noisy", 8'(8'h40 + r), 20, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule